// File: doc/BRIEF.md
# Unaligned Store-Left Lane Steering Unit

This unit sits in the store path of a processor pipeline. It handles the store-word-left operation, which writes the most-significant part of an unaligned word. It takes a base register value, a signed 9-bit displacement, the source register value and three endianness controls. From these it forms the effective address and works out how many of the source word's upper bytes belong in the aligned word that holds that address. It then produces the lane-aligned write data, the matching byte strobes and the memory address.

Address translation is treated as the identity, so the effective address is used directly as the physical address. The address still goes through the reverse-endian and little-endian-memory adjustments. One request is taken per cycle through a valid/ready pair on each side. Results appear one cycle after acceptance and are held for as long as the consumer stalls.

Top module: `store_left_unit`

## Requirements
- R1: The effective address equals the base value plus the displacement, sign-extended to the address width and added modulo 2^AW.
- R2: The byte index is the two low effective-address bits XORed with the big-endian CPU bit, copied onto both bits. The stored word is the source word shifted right by 8×(3 − index). This leaves its top (index + 1) bytes in the lowest lanes and zeros above them.
- R3: Only bits [31:0] of the source value are used. Bits above 31 have no effect on any output.
- R4: On a 64-bit data path, the half-select is effective-address bit 2 XORed with the big-endian CPU bit. When it is 0 the word goes into out_data[31:0]. When it is 1 the word goes into out_data[63:32]. The other half is zero.
- R5: out_strb bit i covers out_data[8i+7:8i]. Exactly the lanes 0..index of the selected half are set, so between 1 and 4 strobes are active.
- R6: The output address is the effective address with its three low bits XORed with the reverse-endian bit. When the memory-big-endian input is 0, bits [1:0] are then forced to zero.
- R7: in_ready is high whenever out_valid is low or out_ready is high. A request accepted at a clock edge is presented with out_valid high right after that edge.
- R8: While out_valid is high and out_ready is low, the outputs hold their values and no new request is taken.
- R9: While reset is active, out_valid is low.
- R10: All data lanes whose strobe is clear carry zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| base_val | input | AW | Base register value |
| disp | input | OFF_W | Signed displacement |
| src_val | input | SRC_W | Source register value |
| cpu_big | input | 1 | CPU runs big-endian |
| rev_end | input | 1 | Reverse-endian mode |
| mem_big | input | 1 | Memory is big-endian |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | AW | Memory address |
| out_data | output | DP_W | Lane-aligned write data |
| out_strb | output | DP_W/8 | Byte strobes |

## Verification
The main function is driven over all eight low address offsets with both CPU byte orders. This tells apart the four byte counts and the two half placements, since each combination yields a distinct strobe pattern. The big-endian case with offset 2 inside a word is checked against fixed values, so a shift that is off by one byte cannot pass. Further patterns use a negative displacement to test the sign extension, garbage in the upper source bits, and the reverse-endian and little-endian-memory address adjustments. A stalled consumer is used to show that the outputs hold while a second request waits.

// File: rtl/slu_pkg.sv
package slu_pkg;
   localparam int unsigned LANE_W = 8;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned WORD_B = WORD_W / LANE_W;
   typedef logic [1:0] bidx_t;
endpackage

// File: rtl/slu_addr.sv
module slu_addr #(
   parameter int unsigned AW    = 32,
   parameter int unsigned OFF_W = 9
) (
   input  logic [AW-1:0]    base_val,
   input  logic [OFF_W-1:0] disp,
   input  logic             cpu_big,
   input  logic             rev_end,
   input  logic             mem_big,
   output logic [AW-1:0]    mem_addr,
   output slu_pkg::bidx_t   bidx,
   output logic             half_sel
);
   localparam int unsigned EXT_W = AW - OFF_W;

   logic [AW-1:0] eff;
   logic [2:0]    low3;

   always_comb begin
      eff  = base_val + {{EXT_W{disp[OFF_W-1]}}, disp};
      bidx = eff[1:0] ^ {2{cpu_big}};
      half_sel = eff[2] ^ cpu_big;
      low3 = eff[2:0] ^ {3{rev_end}};
      if (!mem_big) low3[1:0] = 2'b00;
      mem_addr = {eff[AW-1:3], low3};
   end
endmodule

// File: rtl/slu_lane.sv
module slu_lane #(
   parameter int unsigned SRC_W = 64,
   parameter int unsigned DP_W  = 64
) (
   input  logic [SRC_W-1:0]   src_val,
   input  slu_pkg::bidx_t     bidx,
   input  logic               half_sel,
   output logic [DP_W-1:0]    lane_data,
   output logic [DP_W/8-1:0]  lane_strb
);
   import slu_pkg::*;

   logic [WORD_W-1:0] word;
   logic [WORD_W-1:0] wdata;
   logic [WORD_B-1:0] wstrb;
   logic [1:0]        drop;

   assign word = src_val[WORD_W-1:0];
   assign drop = 2'd3 - bidx;
   assign wdata = word >> {drop, 3'b000};

   for (genvar i = 0; i < WORD_B; i++) begin : g_strb
      assign wstrb[i] = (2'(i) <= bidx);
   end

   if (DP_W == 64) begin : g_dw
      assign lane_data = half_sel ? {wdata, {WORD_W{1'b0}}} : {{WORD_W{1'b0}}, wdata};
      assign lane_strb = half_sel ? {wstrb, {WORD_B{1'b0}}} : {{WORD_B{1'b0}}, wstrb};
   end else begin : g_w
      logic unused_half;
      assign unused_half = half_sel;
      assign lane_data = wdata;
      assign lane_strb = wstrb;
   end
endmodule

// File: rtl/store_left_unit.sv
module store_left_unit #(
   parameter int unsigned AW    = 32,
   parameter int unsigned OFF_W = 9,
   parameter int unsigned SRC_W = 64,
   parameter int unsigned DP_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [AW-1:0]     base_val,
   input  logic [OFF_W-1:0]  disp,
   input  logic [SRC_W-1:0]  src_val,
   input  logic              cpu_big,
   input  logic              rev_end,
   input  logic              mem_big,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [AW-1:0]     out_addr,
   output logic [DP_W-1:0]   out_data,
   output logic [DP_W/8-1:0] out_strb
);
   localparam int unsigned STRB_W = DP_W / 8;

   initial begin
      assert (DP_W == 32 || DP_W == 64) else $error("DP_W must be 32 or 64");
      assert (SRC_W >= 32) else $error("SRC_W below 32");
      assert (OFF_W < AW && AW >= 3) else $error("bad address widths");
   end

   logic [AW-1:0]     c_addr;
   slu_pkg::bidx_t    c_bidx;
   logic              c_half;
   logic [DP_W-1:0]   c_data;
   logic [STRB_W-1:0] c_strb;
   logic              take;

   slu_addr #(.AW(AW), .OFF_W(OFF_W)) u_addr (
      .base_val(base_val), .disp(disp), .cpu_big(cpu_big),
      .rev_end(rev_end), .mem_big(mem_big),
      .mem_addr(c_addr), .bidx(c_bidx), .half_sel(c_half)
   );

   slu_lane #(.SRC_W(SRC_W), .DP_W(DP_W)) u_lane (
      .src_val(src_val), .bidx(c_bidx), .half_sel(c_half),
      .lane_data(c_data), .lane_strb(c_strb)
   );

   assign in_ready = !out_valid || out_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_addr  <= '0;
         out_data  <= '0;
         out_strb  <= '0;
      end else begin
         if (take) begin
            out_valid <= 1'b1;
            out_addr  <= c_addr;
            out_data  <= c_data;
            out_strb  <= c_strb;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/slu_chk.sv
module slu_chk #(
   parameter int unsigned AW   = 32,
   parameter int unsigned DP_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [AW-1:0]     out_addr,
   input logic [DP_W-1:0]   out_data,
   input logic [DP_W/8-1:0] out_strb
);
   logic [DP_W-1:0] lane_mask;
   for (genvar i = 0; i < DP_W/8; i++) begin : g_m
      assign lane_mask[8*i +: 8] = {8{out_strb[i]}};
   end

   // R9
   reset_idle_chk: assert property (@(posedge clk) !rst_n |-> !out_valid);

   // R7
   ready_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

   // R7
   accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)
                                  && $stable(out_strb) && $stable(out_addr));

   // R5
   strb_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(out_strb) >= 1 && $countones(out_strb) <= 4));

   // R10
   idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_data & ~lane_mask) == '0));

   if (DP_W == 64) begin : g_half
      // R4
      one_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (out_strb[3:0] == 4'b0 || out_strb[7:4] == 4'b0));
   end
endmodule

bind store_left_unit slu_chk #(.AW(AW), .DP_W(DP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
   .out_data(out_data), .out_strb(out_strb)
);

// File: tb/tb_store_left_unit.sv
module tb_store_left_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] base_val = '0;
   logic [8:0]  disp = '0;
   logic [63:0] src_val = '0;
   logic        cpu_big = 1'b0;
   logic        rev_end = 1'b0;
   logic        mem_big = 1'b1;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_addr;
   logic [63:0] out_data;
   logic [7:0]  out_strb;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   store_left_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .base_val(base_val), .disp(disp), .src_val(src_val),
      .cpu_big(cpu_big), .rev_end(rev_end), .mem_big(mem_big),
      .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
      .out_data(out_data), .out_strb(out_strb)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Expected outputs from the written requirements
   task automatic model(input logic [31:0] b, input logic [8:0] d, input logic [63:0] s,
                        input logic be, input logic rv, input logic mb,
                        output logic [31:0] pa, output logic [63:0] dat, output logic [7:0] st);
      logic [31:0] ea;
      logic [1:0]  idx;
      logic        h;
      ea  = b + {{23{d[8]}}, d};
      idx = ea[1:0] ^ {be, be};
      h   = ea[2] ^ be;
      dat = '0;
      st  = '0;
      for (int k = 0; k <= 3; k++) begin
         if (k <= int'(idx)) begin
            dat[32*h + 8*k +: 8] = s[8*(3 - int'(idx) + k) +: 8];
            st[4*h + k] = 1'b1;
         end
      end
      pa = ea;
      pa[2:0] = ea[2:0] ^ {3{rv}};
      if (!mb) pa[1:0] = 2'b00;
   endtask

   task automatic issue(input logic [31:0] b, input logic [8:0] d, input logic [63:0] s,
                        input logic be, input logic rv, input logic mb);
      @(negedge clk);
      base_val = b; disp = d; src_val = s;
      cpu_big = be; rev_end = rv; mem_big = mb;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic run_one(input string tag, input logic [31:0] b, input logic [8:0] d,
                          input logic [63:0] s, input logic be, input logic rv, input logic mb);
      logic [31:0] pa;
      logic [63:0] dat;
      logic [7:0]  st;
      model(b, d, s, be, rv, mb, pa, dat, st);
      issue(b, d, s, be, rv, mb);
      chk({tag, " R7 valid"}, 64'(out_valid), 64'd1);
      chk({tag, " R2/R4/R10 data"}, out_data, dat);
      chk({tag, " R5 strb"}, 64'(out_strb), 64'(st));
      chk({tag, " R1/R6 addr"}, 64'(out_addr), 64'(pa));
   endtask

   task automatic t_reset();
      chk("R9 reset valid", 64'(out_valid), 64'd0);
      chk("R7 reset ready", 64'(in_ready), 64'd1);
   endtask

   task automatic t_sweep();
      for (int be = 0; be < 2; be++)
         for (int lo = 0; lo < 8; lo++)
            run_one($sformatf("sweep be=%0d lo=%0d", be, lo), 32'h1000_0100 + 32'(lo),
                    9'd0, 64'h0000_0000_8899_AABB, 1'(be), 1'b0, 1'b1);
   endtask

   task automatic t_be_off2();
      // R2 R4 R5: big-endian, low bits 010 -> two bytes src[31:16], upper half
      issue(32'h2000_0000, 9'd2, 64'h0000_0000_ABCD_1234, 1'b1, 1'b0, 1'b1);
      chk("R2 be off2 data", out_data, 64'h0000_ABCD_0000_0000);
      chk("R5 be off2 strb", 64'(out_strb), 64'h30);
   endtask

   task automatic t_neg_disp();
      // R1: 0x100 + (-3)
      run_one("R1 negdisp", 32'h0000_0100, 9'h1FD, 64'h0000_0000_0102_0304, 1'b0, 1'b0, 1'b1);
      chk("R1 negdisp addr", 64'(out_addr), 64'h0000_00FD);
      run_one("R1 wrap", 32'h0000_0001, 9'h1FE, 64'h0000_0000_5566_7788, 1'b1, 1'b0, 1'b1);
   endtask

   task automatic t_upper_src();
      // R3: upper source bits ignored
      run_one("R3 upper", 32'h0000_0043, 9'd0, 64'hDEAD_BEEF_1122_3344, 1'b0, 1'b0, 1'b1);
      chk("R3 upper data", out_data, 64'h0000_0000_1122_3344 >> 0 & 64'h0000_0000_1122_3344);
   endtask

   task automatic t_addr_modes();
      // R6
      run_one("R6 rev", 32'h0000_0205, 9'd0, 64'h0000_0000_CAFE_F00D, 1'b0, 1'b1, 1'b1);
      chk("R6 rev addr", 64'(out_addr), 64'h0000_0202);
      run_one("R6 lemem", 32'h0000_0207, 9'd0, 64'h0000_0000_CAFE_F00D, 1'b1, 1'b1, 1'b0);
      chk("R6 lemem addr", 64'(out_addr), 64'h0000_0200);
   endtask

   task automatic t_stall();
      logic [31:0] pa;
      logic [63:0] dat;
      logic [7:0]  st;
      logic [31:0] pb;
      logic [63:0] db;
      logic [7:0]  sb;
      model(32'h3000_0001, 9'd0, 64'h0000_0000_1357_9BDF, 1'b0, 1'b0, 1'b1, pa, dat, st);
      model(32'h3000_0006, 9'd0, 64'h0000_0000_2468_ACE0, 1'b1, 1'b0, 1'b1, pb, db, sb);
      @(negedge clk);
      out_ready = 1'b0;
      issue(32'h3000_0001, 9'd0, 64'h0000_0000_1357_9BDF, 1'b0, 1'b0, 1'b1);
      base_val = 32'h3000_0006; src_val = 64'h0000_0000_2468_ACE0; cpu_big = 1'b1;
      in_valid = 1'b1;
      for (int c = 0; c < 3; c++) begin
         chk("R8 stall ready", 64'(in_ready), 64'd0);
         chk("R8 stall data", out_data, dat);
         chk("R8 stall addr", 64'(out_addr), 64'(pa));
         @(negedge clk);
      end
      out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 released data", out_data, db);
      chk("R8 released strb", 64'(out_strb), 64'(sb));
      @(negedge clk);
      chk("R7 drained", 64'(out_valid), 64'd0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_sweep();
      t_be_off2();
      t_neg_disp();
      t_upper_src();
      t_addr_modes();
      t_stall();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule